// File: doc/BRIEF.md
# Pluggable Module Power-Up Interlock Controller

This block is the low-speed management sequencer of a hot-pluggable optical module. After the module-reset pin is released, it holds the module in an initialization phase. It then waits in low power until the host and the soft register bit both release the low-power request. Before any step into high power, it checks a host cooling-capacity code against the module's own power class. When the host cannot cool the module, the module stays in low power and reports an interlock flag. This case does not count as a fault.

The host control pins are asynchronous to the block clock and pass through a parameterised synchronizer. Soft register bits and the static power class arrive as plain parallel inputs. The block produces the active-low reset for the internal transceiver ICs, the power-up-done, ready and fault alarms, an active-low global alarm, the transmitter enable, and the stored interlock result, which software can read.

Top module: `plug_pwr_seq`

## Requirements
- R1: `ic_reset_n` is low while `soft_ic_reset` is 1 (in the same cycle) or while the synchronized `pin_ctl_rst_n` is 0. A change on the pin shows after SYNC_STAGES clock edges. `ic_reset_n` is high only when the pin is 1 and the soft bit is 0.
- R2: A low synchronized `pin_mod_rst_n`, or an active IC reset, sends the sequencer to the reset state on the next edge from any state. All alarm outputs and `tx_enable` then read 0. The stored cooling code and `interlock_stat` are cleared.
- R3: Once reset is released, initialization lasts exactly INIT_CYCLES cycles. The two interlock pins are captured once, in its last cycle (`pin_il_msb` is code bit 1, `pin_il_lsb` is code bit 0). Changes on these pins after that have no effect until the next initialization.
- R4: The cooling code 2'b11 means no limit, so the interlock result is 0. Codes 2'b00, 2'b01 and 2'b10 allow power class index 0, 1 and 2 at most. `power_class` is 0..3 for classes 1..4. The result is 1 when `power_class` is greater than the code.
- R5: The interlock comparison, and so any update of `interlock_stat`, happens only in low power while the synchronized `pin_lowpwr` and `soft_lowpwr` are both 0. `interlock_stat` shows the result one edge later.
- R6: An interlock result of 1 keeps the sequencer in low power, with `alm_fault` at 0. A result of 0 moves it into power-up on the same edge.
- R7: Power-up lasts HPUP_CYCLES cycles. `alm_pwr_done` and `alm_ready` are then both 1. When a passing comparison is made, they rise 1+HPUP_CYCLES edges later.
- R8: A low-power request in power-up or in ready (`soft_lowpwr` at 1, or the synchronized `pin_lowpwr` at 1) returns to low power on the next edge. This clears `alm_pwr_done` and `alm_ready`.
- R9: `tx_enable` is 1 only in the ready state while the synchronized `pin_tx_off` is 0.
- R10: `fault_det` at 1 in low power, power-up or ready enters the fault state on the next edge, and `alm_fault` reads 1. Only R2 leaves the fault state. A low-power request does not.
- R11: `glb_alarm_n` goes low one edge after the fault state is entered or after `interlock_stat` becomes 1. It stays low until the sequencer has spent a cycle in the reset state.
- R12: While `rst_n` is low, every alarm, `tx_enable` and `interlock_stat` is 0, `glb_alarm_n` is 1 and `ic_reset_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_mod_rst_n | input | 1 | Module reset pin, active low |
| pin_ctl_rst_n | input | 1 | Hardware IC reset control pin, active low |
| pin_lowpwr | input | 1 | Low-power request pin, active high |
| pin_tx_off | input | 1 | Transmitter disable pin, active high |
| pin_il_lsb | input | 1 | Cooling code bit 0 |
| pin_il_msb | input | 1 | Cooling code bit 1 |
| soft_ic_reset | input | 1 | Soft IC reset register bit |
| soft_lowpwr | input | 1 | Soft low-power register bit |
| power_class | input | 2 | Static module power class index (0..3 for classes 1..4) |
| fault_det | input | 1 | Fault condition from module monitors |
| ic_reset_n | output | 1 | Active-low reset to internal transceiver ICs |
| alm_pwr_done | output | 1 | High-power-up completed alarm |
| alm_ready | output | 1 | Module ready alarm |
| alm_fault | output | 1 | Module fault alarm |
| glb_alarm_n | output | 1 | Active-low global alarm |
| tx_enable | output | 1 | Transmitter lane enable |
| interlock_stat | output | 1 | Stored interlock result for register reads |

## Verification
The latency of each result is fixed, so every check samples in the exact cycle that result is due. Soft bits reach `ic_reset_n` within the cycle. They reach the state outputs after one edge. Pin changes take SYNC_STAGES edges to show on `ic_reset_n` and `tx_enable`, and one more edge to move the state. From reset release, ready arrives after 2+1+INIT_CYCLES+1+HPUP_CYCLES edges. The global alarm trails its source by one edge. The bench drives and samples 1 ns after a rising edge and counts edges with one step task. It checks that an output is still low one edge before its due cycle and high in the due cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [2:0] {
      ST_RESET  = 3'd0,
      ST_INIT   = 3'd1,
      ST_LOWPWR = 3'd2,
      ST_HPUP   = 3'd3,
      ST_READY  = 3'd4,
      ST_FAULT  = 3'd5
   } pps_state_e;

   localparam int CODE_W  = 2;
   localparam int CLASS_W = 2;
   localparam logic [CODE_W-1:0] CODE_NO_LIMIT = 2'b11;

   // interlock is raised when the module needs more cooling than the host grants
   function automatic logic il_eval(input logic [CODE_W-1:0]  code,
                                    input logic [CLASS_W-1:0] cls);
      return (code != CODE_NO_LIMIT) && (cls > code);
   endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end

         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pps_interlock.sv
module pps_interlock
   import pps_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               sample,
   input  logic               eval,
   input  logic [CODE_W-1:0]  il_pins,
   input  logic [CLASS_W-1:0] power_class,
   output logic               il_fail,
   output logic               il_stat
);

   logic [CODE_W-1:0] code_q;

   assign il_fail = il_eval(code_q, power_class);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         il_stat <= 1'b0;
      end else if (clr) begin
         code_q  <= '0;
         il_stat <= 1'b0;
      end else begin
         if (sample) code_q  <= il_pins;
         if (eval)   il_stat <= il_fail;
      end
   end

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
#(
   parameter int INIT_CYCLES = 12,
   parameter int HPUP_CYCLES = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_reset,
   input  logic       lp_req,
   input  logic       fault_det,
   input  logic       il_fail,
   output pps_state_e state,
   output logic       sample_stb,
   output logic       eval_stb
);

   localparam int MAX_CYC = (INIT_CYCLES > HPUP_CYCLES) ? INIT_CYCLES : HPUP_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);
   localparam logic [CNT_W-1:0] HPUP_LAST = CNT_W'(HPUP_CYCLES - 1);

   pps_state_e      st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign state      = st_q;
   assign sample_stb = (st_q == ST_INIT) && (cnt_q == INIT_LAST) && !go_reset;
   assign eval_stb   = (st_q == ST_LOWPWR) && !go_reset && !fault_det && !lp_req;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (go_reset) begin
         st_d  = ST_RESET;
         cnt_d = '0;
      end else begin
         unique case (st_q)
            ST_RESET: begin
               st_d  = ST_INIT;
               cnt_d = '0;
            end
            ST_INIT: begin
               if (cnt_q == INIT_LAST) begin
                  st_d  = ST_LOWPWR;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_LOWPWR: begin
               if (fault_det) begin
                  st_d = ST_FAULT;
               end else if (!lp_req && !il_fail) begin
                  st_d  = ST_HPUP;
                  cnt_d = '0;
               end
            end
            ST_HPUP: begin
               if (fault_det) begin
                  st_d = ST_FAULT;
               end else if (lp_req) begin
                  st_d = ST_LOWPWR;
               end else if (cnt_q == HPUP_LAST) begin
                  st_d  = ST_READY;
                  cnt_d = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            ST_READY: begin
               if (fault_det)   st_d = ST_FAULT;
               else if (lp_req) st_d = ST_LOWPWR;
            end
            ST_FAULT: st_d = ST_FAULT;
            default:  st_d = ST_RESET;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RESET;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/pps_alarm.sv
module pps_alarm
   import pps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pps_state_e state,
   input  logic       il_stat,
   input  logic       tx_off,
   output logic       alm_pwr_done,
   output logic       alm_ready,
   output logic       alm_fault,
   output logic       glb_alarm_n,
   output logic       tx_enable
);

   logic flt_lat_q, il_lat_q;

   assign alm_pwr_done = (state == ST_READY);
   assign alm_ready    = (state == ST_READY);
   assign alm_fault    = (state == ST_FAULT);
   assign tx_enable    = (state == ST_READY) && !tx_off;
   assign glb_alarm_n  = !(flt_lat_q || il_lat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flt_lat_q <= 1'b0;
         il_lat_q  <= 1'b0;
      end else if (state == ST_RESET) begin
         flt_lat_q <= 1'b0;
         il_lat_q  <= 1'b0;
      end else begin
         flt_lat_q <= flt_lat_q || (state == ST_FAULT);
         il_lat_q  <= il_lat_q || il_stat;
      end
   end

endmodule

// File: rtl/plug_pwr_seq.sv
module plug_pwr_seq
   import pps_pkg::*;
#(
   parameter int INIT_CYCLES = 12,
   parameter int HPUP_CYCLES = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_mod_rst_n,
   input  logic               pin_ctl_rst_n,
   input  logic               pin_lowpwr,
   input  logic               pin_tx_off,
   input  logic               pin_il_lsb,
   input  logic               pin_il_msb,
   input  logic               soft_ic_reset,
   input  logic               soft_lowpwr,
   input  logic [CLASS_W-1:0] power_class,
   input  logic               fault_det,
   output logic               ic_reset_n,
   output logic               alm_pwr_done,
   output logic               alm_ready,
   output logic               alm_fault,
   output logic               glb_alarm_n,
   output logic               tx_enable,
   output logic               interlock_stat
);

   localparam int PIN_W = 6;
   // bit order: mod_rst_n, ctl_rst_n, lowpwr, tx_off, il_msb, il_lsb
   localparam logic [PIN_W-1:0] PIN_RST = 6'b00_11_00;

   generate
      if (INIT_CYCLES < 1 || HPUP_CYCLES < 1) begin : g_bad_cycles
         $error("plug_pwr_seq: phase lengths must be at least one cycle");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("plug_pwr_seq: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic [PIN_W-1:0] pins_raw, pins_s;
   logic mod_rst_n_s, ctl_rst_n_s, lowpwr_s, tx_off_s;
   logic [CODE_W-1:0] il_s;
   logic ic_rst, go_reset, lp_req;
   logic sample_stb, eval_stb, il_fail;
   pps_state_e state;

   assign pins_raw = {pin_mod_rst_n, pin_ctl_rst_n, pin_lowpwr, pin_tx_off,
                      pin_il_msb, pin_il_lsb};

   pps_sync #(.STAGES(SYNC_STAGES), .W(PIN_W), .RST_VAL(PIN_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign {mod_rst_n_s, ctl_rst_n_s, lowpwr_s, tx_off_s} = pins_s[5:2];
   assign il_s       = pins_s[1:0];
   assign ic_rst     = !ctl_rst_n_s || soft_ic_reset;
   assign ic_reset_n = !ic_rst;
   assign go_reset   = !mod_rst_n_s || ic_rst;
   assign lp_req     = lowpwr_s || soft_lowpwr;

   pps_fsm #(.INIT_CYCLES(INIT_CYCLES), .HPUP_CYCLES(HPUP_CYCLES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_reset   (go_reset),
      .lp_req     (lp_req),
      .fault_det  (fault_det),
      .il_fail    (il_fail),
      .state      (state),
      .sample_stb (sample_stb),
      .eval_stb   (eval_stb)
   );

   pps_interlock u_il (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (go_reset),
      .sample      (sample_stb),
      .eval        (eval_stb),
      .il_pins     (il_s),
      .power_class (power_class),
      .il_fail     (il_fail),
      .il_stat     (interlock_stat)
   );

   pps_alarm u_alm (
      .clk          (clk),
      .rst_n        (rst_n),
      .state        (state),
      .il_stat      (interlock_stat),
      .tx_off       (tx_off_s),
      .alm_pwr_done (alm_pwr_done),
      .alm_ready    (alm_ready),
      .alm_fault    (alm_fault),
      .glb_alarm_n  (glb_alarm_n),
      .tx_enable    (tx_enable)
   );

endmodule

// File: rtl/pps_checker.sv
module pps_checker (
   input logic clk,
   input logic rst_n,
   input logic soft_ic_reset,
   input logic ic_reset_n,
   input logic alm_ready,
   input logic alm_fault,
   input logic glb_alarm_n,
   input logic tx_enable,
   input logic interlock_stat
);

   a_r1_soft_reset_ic: assert property (@(posedge clk) disable iff (!rst_n)
      soft_ic_reset |-> !ic_reset_n);

   a_r6_held_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      interlock_stat |-> !alm_ready);

   a_r9_tx_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enable |-> alm_ready);

   a_r10_ready_not_from_fault: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_ready) |-> !$past(alm_fault));

   a_r11_fault_global: assert property (@(posedge clk) disable iff (!rst_n)
      alm_fault |=> !glb_alarm_n);

endmodule

bind plug_pwr_seq pps_checker u_chk (.*);

// File: tb/tb_plug_pwr_seq.sv
`timescale 1ns/100ps
module tb_plug_pwr_seq;

   localparam int INIT_C = 12;
   localparam int HPUP_C = 6;
   localparam int SYN    = 2;

   // {code[1:0], class[1:0], expected interlock}
   localparam logic [4:0] VEC [16] = '{
      5'b00_00_0, 5'b00_01_1, 5'b00_10_1, 5'b00_11_1,
      5'b01_00_0, 5'b01_01_0, 5'b01_10_1, 5'b01_11_1,
      5'b10_00_0, 5'b10_01_0, 5'b10_10_0, 5'b10_11_1,
      5'b11_00_0, 5'b11_01_0, 5'b11_10_0, 5'b11_11_0
   };

   logic clk = 1'b0;
   logic rst_n;
   logic pin_mod_rst_n, pin_ctl_rst_n, pin_lowpwr, pin_tx_off;
   logic pin_il_lsb, pin_il_msb, soft_ic_reset, soft_lowpwr, fault_det;
   logic [1:0] power_class;
   logic ic_reset_n, alm_pwr_done, alm_ready, alm_fault, glb_alarm_n;
   logic tx_enable, interlock_stat;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   plug_pwr_seq #(.INIT_CYCLES(INIT_C), .HPUP_CYCLES(HPUP_C), .SYNC_STAGES(SYN)) dut (
      .clk(clk), .rst_n(rst_n), .pin_mod_rst_n(pin_mod_rst_n),
      .pin_ctl_rst_n(pin_ctl_rst_n), .pin_lowpwr(pin_lowpwr), .pin_tx_off(pin_tx_off),
      .pin_il_lsb(pin_il_lsb), .pin_il_msb(pin_il_msb), .soft_ic_reset(soft_ic_reset),
      .soft_lowpwr(soft_lowpwr), .power_class(power_class), .fault_det(fault_det),
      .ic_reset_n(ic_reset_n), .alm_pwr_done(alm_pwr_done), .alm_ready(alm_ready),
      .alm_fault(alm_fault), .glb_alarm_n(glb_alarm_n), .tx_enable(tx_enable),
      .interlock_stat(interlock_stat)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic restart(input logic [1:0] code);
      pin_mod_rst_n = 1'b0;
      step(4);
      {pin_il_msb, pin_il_lsb} = code;
      pin_mod_rst_n = 1'b1;
      step(30);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      pin_mod_rst_n = 1'b1; pin_ctl_rst_n = 1'b1; pin_lowpwr = 1'b0; pin_tx_off = 1'b1;
      {pin_il_msb, pin_il_lsb} = 2'b11;
      soft_ic_reset = 1'b0; soft_lowpwr = 1'b0; fault_det = 1'b0; power_class = 2'd0;
      step(3);
      // R12 reset values
      check("R12 ready", alm_ready, 0);
      check("R12 pwr_done", alm_pwr_done, 0);
      check("R12 fault", alm_fault, 0);
      check("R12 glb", glb_alarm_n, 1);
      check("R12 tx", tx_enable, 0);
      check("R12 ic_reset_n", ic_reset_n, 0);
      check("R12 il", interlock_stat, 0);
      rst_n = 1'b1;
      // R3 R7 exact power-up latency: 2 sync + 1 + INIT + 1 + HPUP edges
      step(SYN + 1 + INIT_C + HPUP_C);
      check("R3 ready early", alm_ready, 0);
      check("R1 ic_reset_n released", ic_reset_n, 1);
      step(1);
      check("R3 ready due", alm_ready, 1);
      check("R7 pwr_done", alm_pwr_done, 1);

      // R9 transmit enable follows synced pin
      pin_tx_off = 1'b0;
      step(1);
      check("R9 tx early", tx_enable, 0);
      step(1);
      check("R9 tx on", tx_enable, 1);
      pin_tx_off = 1'b1;
      step(2);
      check("R9 tx off", tx_enable, 0);
      pin_tx_off = 1'b0;
      step(2);

      // R8 soft low power
      soft_lowpwr = 1'b1;
      step(1);
      check("R8 ready drop", alm_ready, 0);
      check("R8 pwr_done drop", alm_pwr_done, 0);
      check("R9 tx drop", tx_enable, 0);
      soft_lowpwr = 1'b0;
      step(HPUP_C);
      check("R7 ready early", alm_ready, 0);
      step(1);
      check("R7 ready due", alm_ready, 1);
      // R8 pin low power
      pin_lowpwr = 1'b1;
      step(SYN);
      check("R8 pin not yet", alm_ready, 1);
      step(1);
      check("R8 pin drop", alm_ready, 0);
      pin_lowpwr = 1'b0;
      step(12);
      check("R8 back ready", alm_ready, 1);

      // R10 R11 fault
      fault_det = 1'b1;
      step(1);
      fault_det = 1'b0;
      check("R10 fault", alm_fault, 1);
      check("R10 ready off", alm_ready, 0);
      check("R11 glb not yet", glb_alarm_n, 1);
      step(1);
      check("R11 glb low", glb_alarm_n, 0);
      soft_lowpwr = 1'b1;
      step(5);
      check("R10 sticky", alm_fault, 1);
      soft_lowpwr = 1'b0;

      // R1 R2 soft IC reset
      soft_ic_reset = 1'b1;
      #1;
      check("R1 soft immediate", ic_reset_n, 0);
      step(1);
      check("R2 fault cleared", alm_fault, 0);
      check("R11 glb still", glb_alarm_n, 0);
      step(1);
      check("R11 glb clear", glb_alarm_n, 1);
      soft_ic_reset = 1'b0;
      #1;
      check("R1 soft release", ic_reset_n, 1);
      step(1 + INIT_C + 1 + HPUP_C);
      check("R2 ready again", alm_ready, 1);

      // R1 pin IC reset
      pin_ctl_rst_n = 1'b0;
      step(SYN - 1);
      check("R1 pin early", ic_reset_n, 1);
      step(1);
      check("R1 pin", ic_reset_n, 0);
      step(1);
      check("R2 ic reset", alm_ready, 0);
      pin_ctl_rst_n = 1'b1;
      step(SYN);
      check("R1 pin release", ic_reset_n, 1);
      step(25);
      check("R2 ready after ic", alm_ready, 1);

      // R2 module reset pin
      pin_mod_rst_n = 1'b0;
      step(SYN);
      check("R2 pin early", alm_ready, 1);
      step(1);
      check("R2 pin reset", alm_ready, 0);
      pin_mod_rst_n = 1'b1;
      step(30);

      // R4 R6 table of codes and classes
      foreach (VEC[i]) begin
         soft_lowpwr = 1'b1;
         restart(VEC[i][4:3]);
         power_class = VEC[i][2:1];
         soft_lowpwr = 1'b0;
         step(HPUP_C + 4);
         check($sformatf("R4 il row %0d", i), interlock_stat, int'(VEC[i][0]));
         check($sformatf("R6 ready row %0d", i), alm_ready, int'(!VEC[i][0]));
         check($sformatf("R6 nofault row %0d", i), alm_fault, 0);
         check($sformatf("R11 glb row %0d", i), glb_alarm_n, int'(!VEC[i][0]));
      end

      // R3 interlock sampled once
      soft_lowpwr = 1'b0;
      power_class = 2'd2;
      restart(2'b00);
      check("R6 held", alm_ready, 0);
      check("R6 held nofault", alm_fault, 0);
      {pin_il_msb, pin_il_lsb} = 2'b11;
      step(20);
      check("R3 late pins ignored", alm_ready, 0);
      check("R3 il kept", interlock_stat, 1);
      restart(2'b11);
      check("R3 resampled", alm_ready, 1);
      check("R2 il cleared", interlock_stat, 0);
      check("R2 glb cleared", glb_alarm_n, 1);

      // R5 no comparison while low power requested
      soft_lowpwr = 1'b1;
      restart(2'b00);
      check("R5 no eval", interlock_stat, 0);
      check("R5 glb idle", glb_alarm_n, 1);
      soft_lowpwr = 1'b0;
      step(1);
      check("R5 eval", interlock_stat, 1);
      check("R11 glb one edge later", glb_alarm_n, 1);
      step(1);
      check("R11 glb il", glb_alarm_n, 0);

      // R10 fault from low power
      fault_det = 1'b1;
      step(1);
      fault_det = 1'b0;
      check("R10 fault from lowpwr", alm_fault, 1);

      summary();
      $finish;
   end

endmodule